// File: doc/BRIEF.md
# Radix-2 Signed-Digit Adder with Transfer Flags

This block adds two N-digit redundant binary numbers whose digits each take a value in {-1, 0, +1}. It returns an (N+1)-digit redundant binary sum. The block is purely combinational, and its delay does not grow with N. Every output digit depends only on the operand digits at its own position and at the two positions just below it.

Radix 2 leaves no spare interim-sum values, so a single carry-and-remainder split per position cannot keep the result digits in range. To get around this, each position raises a flag that tells the position above which sign of carry it might send. The position above reads that flag and picks its carry and interim sum so that adding the incoming carry can never push a digit outside {-1, 0, +1}. Downstream logic can feed the result straight back in as an operand, or convert it to two's complement somewhere else.

Top module: `rb_tdadd`

## Requirements
- R1: Each digit uses two bits at bits [2i+1:2i], coded as 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1. No output digit is ever coded 2'b10.
- R2: For legal operands, the integer value of the output, sum of digit(i)·2^i over i = 0..N, equals value(X) + value(Y).
- R3: When both operands are all zeros, every output digit is 2'b00.
- R4: Output digit i, for every i from 0 to N, depends only on operand digits i, i-1 and i-2. Changing operand digits below position i-2 leaves it unchanged.
- R5: An operand digit coded 2'b10 gives the same output as the same operand with that digit coded 2'b00.
- R6: When the two top operand digits sum to zero, the top output digit s(N) is 0.
- R7: The sum is exact at every operand pattern, including the extremes: all +1 digits on both operands, and all -1 digits on both operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 2*N | First operand, N signed digits, digit i at bits [2i+1:2i] |
| y | input | 2*N | Second operand, same layout as x |
| s | output | 2*N+2 | Redundant sum, N+1 signed digits, digit N at the top |

## Verification
Whenever the operands are known, the assertions check that no output digit uses the illegal code (R1), that the output value equals the sum of the operand values (R2), that zero operands give a zero result (R3), and that a zero top digit sum gives a zero top result digit (R6). Three behaviours need pairs of stimuli that only the bench's scenarios can set up. The two-position locality of R4 needs a result compared before and after perturbing low digits. The handling of the unused code in R5 needs a result compared against the same operand with that digit coded 0. The extreme patterns of R7 need the specific values chosen. The bench runs every legal operand pair exhaustively at four digits and random operands at sixteen digits.

// File: rtl/rb_tdadd.sv
module rb_tdadd #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] x,
  input  logic [2*N-1:0] y,
  output logic [2*N+1:0] s
);

  function automatic logic signed [2:0] dig(input logic [1:0] c);
    case (c)
      2'b01:   return 3'sd1;
      2'b11:   return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  function automatic logic [1:0] enc(input logic signed [2:0] v);
    return {v[2], v != 3'sd0};
  endfunction

  logic signed [2:0] ic [N+1];
  logic signed [2:0] is_ [N];
  logic              tf [N+1];

  always_comb begin
    ic[0] = 3'sd0;
    tf[0] = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic signed [2:0] sm;
      sm = dig(x[2*i +: 2]) + dig(y[2*i +: 2]);
      tf[i+1] = (x[2*i +: 2] == 2'b11) || (y[2*i +: 2] == 2'b11);
      case (sm)
        3'b010: begin ic[i+1] = 3'sd1;  is_[i] = 3'sd0; end
        3'b110: begin ic[i+1] = -3'sd1; is_[i] = 3'sd0; end
        3'b001: begin
          if (tf[i]) begin ic[i+1] = 3'sd0; is_[i] = 3'sd1; end
          else       begin ic[i+1] = 3'sd1; is_[i] = -3'sd1; end
        end
        3'b111: begin
          if (tf[i]) begin ic[i+1] = -3'sd1; is_[i] = 3'sd1; end
          else       begin ic[i+1] = 3'sd0;  is_[i] = -3'sd1; end
        end
        default: begin ic[i+1] = 3'sd0; is_[i] = 3'sd0; end
      endcase
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_dig
      assign s[2*g +: 2] = enc(is_[g] + ic[g]);
    end
  endgenerate

  assign s[2*N +: 2] = enc(ic[N]);

endmodule

module rb_tdadd_chk #(
  parameter int N = 8
) (
  input logic [2*N-1:0] x,
  input logic [2*N-1:0] y,
  input logic [2*N+1:0] s
);

  function automatic longint val(input logic [2*N+1:0] v, input int nd);
    longint acc;
    acc = 0;
    for (int i = 0; i < nd; i++) begin
      if (v[2*i +: 2] == 2'b01) acc += (longint'(1) <<< i);
      if (v[2*i +: 2] == 2'b11) acc -= (longint'(1) <<< i);
    end
    return acc;
  endfunction

  function automatic logic legal(input logic [2*N-1:0] v);
    for (int i = 0; i < N; i++)
      if (v[2*i +: 2] == 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  always_comb begin
    if (!$isunknown(x) && !$isunknown(y)) begin
      for (int i = 0; i <= N; i++) begin
        assert_digit_code_R1: assert (s[2*i +: 2] != 2'b10)
          else $error("illegal output digit code at %0d", i);
      end
      if (legal(x) && legal(y)) begin
        assert_value_sum_R2: assert (val(s, N+1) == val({2'b00, x}, N) + val({2'b00, y}, N))
          else $error("output value mismatch");
      end
      if (x == '0 && y == '0) begin
        assert_zero_in_R3: assert (s == '0)
          else $error("zero operands gave nonzero result");
      end
      if ((x[2*N-1 -: 2] == 2'b01 && y[2*N-1 -: 2] == 2'b11) ||
          (x[2*N-1 -: 2] == 2'b11 && y[2*N-1 -: 2] == 2'b01) ||
          (x[2*N-1 -: 2] != 2'b01 && x[2*N-1 -: 2] != 2'b11 &&
           y[2*N-1 -: 2] != 2'b01 && y[2*N-1 -: 2] != 2'b11)) begin
        assert_top_zero_R6: assert (s[2*N +: 2] == 2'b00)
          else $error("top digit nonzero for zero top sum");
      end
    end
  end

endmodule

bind rb_tdadd rb_tdadd_chk #(.N(N)) u_chk (.x(x), .y(y), .s(s));

// File: tb/sim_rb_tdadd.sv
module sim_rb_tdadd;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  x4, y4;
  logic [9:0]  s4;
  logic [31:0] x16, y16;
  logic [33:0] s16;

  rb_tdadd #(.N(4))  u0 (.x(x4),  .y(y4),  .s(s4));
  rb_tdadd #(.N(16)) u1 (.x(x16), .y(y16), .s(s16));

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam int NV = 7;
  localparam logic [7:0] TX [NV] = '{8'h01, 8'h55, 8'hFF, 8'h70, 8'hFF, 8'h13, 8'h00};
  localparam logic [7:0] TY [NV] = '{8'h01, 8'h55, 8'h55, 8'h03, 8'hFF, 8'hC1, 8'h00};
  localparam int         TV [NV] = '{2, 30, 0, 3, -30, -4, 0};

  function automatic longint val(input logic [33:0] v, input int nd);
    longint acc = 0;
    for (int i = 0; i < nd; i++) begin
      if (v[2*i +: 2] == 2'b01) acc += (longint'(1) <<< i);
      if (v[2*i +: 2] == 2'b11) acc -= (longint'(1) <<< i);
    end
    return acc;
  endfunction

  function automatic bit clean(input logic [33:0] v, input int nd);
    for (int i = 0; i < nd; i++)
      if (v[2*i +: 2] == 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [1:0] code(input int t);
    return (t == 0) ? 2'b00 : (t == 1) ? 2'b01 : 2'b11;
  endfunction

  function automatic logic [7:0] enc4(input int k);
    logic [7:0] r;
    int q = k;
    for (int d = 0; d < 4; d++) begin
      r[2*d +: 2] = code(q % 3);
      q = q / 3;
    end
    return r;
  endfunction

  function automatic logic [31:0] rnd16();
    logic [31:0] r;
    for (int d = 0; d < 16; d++) r[2*d +: 2] = code(int'($urandom % 3));
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    x4 = '0; y4 = '0; x16 = '0; y16 = '0;
    settle();
    check(s4 == '0, "R3", longint'(s4), 0);
    check(s16 == '0, "R3", longint'(s16), 0);

    for (int k = 0; k < NV; k++) begin
      x4 = TX[k]; y4 = TY[k];
      settle();
      check(val({24'b0, s4}, 5) == longint'(TV[k]), "R2 R7 table", val({24'b0, s4}, 5), TV[k]);
      check(clean({24'b0, s4}, 5), "R1 table", longint'(s4), 0);
    end

    for (int a = 0; a < 81; a++) begin
      for (int b = 0; b < 81; b++) begin
        x4 = enc4(a); y4 = enc4(b);
        #1;
        check(val({24'b0, s4}, 5) == val({26'b0, x4}, 4) + val({26'b0, y4}, 4),
              "R2 exhaustive", val({24'b0, s4}, 5), val({26'b0, x4}, 4) + val({26'b0, y4}, 4));
        check(clean({24'b0, s4}, 5), "R1 exhaustive", longint'(s4), 0);
      end
    end
    settle();

    x16 = 32'h5555_5555; y16 = 32'h5555_5555;
    settle();
    check(val(s16, 17) == 131070, "R7 all plus", val(s16, 17), 131070);
    x16 = 32'hFFFF_FFFF; y16 = 32'hFFFF_FFFF;
    settle();
    check(val(s16, 17) == -131070, "R7 all minus", val(s16, 17), -131070);

    for (int n = 0; n < 2000; n++) begin
      x16 = rnd16(); y16 = rnd16();
      #1;
      check(val(s16, 17) == val({2'b0, x16}, 16) + val({2'b0, y16}, 16),
            "R2 random", val(s16, 17), val({2'b0, x16}, 16) + val({2'b0, y16}, 16));
      check(clean(s16, 17), "R1 random", longint'(s16[31:0]), 0);
    end
    settle();

    for (int n = 0; n < 200; n++) begin
      int j;
      logic [33:0] ref_s;
      logic [31:0] mask;
      j = 3 + int'($urandom % 14);
      x16 = rnd16(); y16 = rnd16();
      settle();
      ref_s = s16;
      mask = (32'h1 << (2*(j-2))) - 32'h1;
      x16 = (x16 & ~mask) | (rnd16() & mask);
      y16 = (y16 & ~mask) | (rnd16() & mask);
      settle();
      check((s16 >> (2*j)) == (ref_s >> (2*j)), "R4 locality",
            longint'(s16 >> (2*j)), longint'(ref_s >> (2*j)));
    end

    for (int n = 0; n < 200; n++) begin
      int p;
      logic [33:0] ref_s;
      logic [31:0] base;
      p = int'($urandom % 16);
      base = rnd16();
      base[2*p +: 2] = 2'b00;
      x16 = base; y16 = rnd16();
      settle();
      ref_s = s16;
      x16[2*p +: 2] = 2'b10;
      settle();
      check(s16 == ref_s, "R5 unused code", longint'(s16), longint'(ref_s));
    end

    for (int n = 0; n < 50; n++) begin
      x4 = enc4(int'($urandom % 27)); y4 = enc4(int'($urandom % 27));
      case (n % 3)
        0: begin x4[7:6] = 2'b01; y4[7:6] = 2'b11; end
        1: begin x4[7:6] = 2'b11; y4[7:6] = 2'b01; end
        default: begin x4[7:6] = 2'b00; y4[7:6] = 2'b00; end
      endcase
      settle();
      check(s4[9:8] == 2'b00, "R6 top digit", longint'(s4[9:8]), 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule